// File: doc/BRIEF.md
# Receive Phase Compensation FIFO

This block moves receive-side words from the transceiver's low-speed parallel clock domain into the user logic clock domain. Each word holds a data field and a status field, and the two travel together. Both clocks run at the same frequency and differ only in phase. The buffer holds four entries, and its pointers cross between the domains in Gray code. The read side begins draining once it sees two stored words. After that it takes one word on every read clock.

The input has no back-pressure. The upstream receive path cannot stall, so there is no ready signal. A word offered while four words are unread is dropped, and a sticky overflow flag records the loss. On the output, `rd_valid` marks the stream once it has started. There is no ready input either: the consumer must take a word on every read clock. If the read side finds the buffer empty when a word is due, it repeats the last word and raises a sticky underflow flag. A frequency mismatch between the clocks shows up as one of these two flags.

Setting `reg_mode` bypasses the buffer. The incoming word then passes through a single register clocked by the read clock, for designs where both sides share one clock. `reg_mode` is a static setting and changes only while both domains are in reset.

Top module: `rx_phase_fifo`

## Requirements
- R1: After both resets are released, `rd_valid`, `ovfl` and `unfl` are low.
- R2: With `reg_mode` low, every accepted word appears on `{rd_stat, rd_data}` exactly once and in write order, with its status and data kept together.
- R3: Reading starts only when the read side sees at least two stored words. With a single word stored, `rd_valid` and `unfl` stay low.
- R4: Once reading has started, one read is attempted on every `rd_clk` edge, and `rd_valid` stays high until reset.
- R5: A write offered while four words are unread is dropped, and `ovfl` is set. No more than four words are ever held, the surviving words keep their order, and `ovfl` stays set until `wr_rst_n` is asserted, whatever the read domain does.
- R6: A read that falls due while the buffer is empty sets `unfl` and leaves `{rd_stat, rd_data}` at the last word delivered. `unfl` stays set until `rd_rst_n` is asserted.
- R7: With `reg_mode` high, `rd_data`, `rd_stat` and `rd_valid` equal `wr_data`, `wr_stat` and `wr_valid` as sampled on the previous `rd_clk` rising edge.
- R8: With `reg_mode` high, `ovfl` and `unfl` stay low at any write clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Receive-side parallel clock (write domain) |
| wr_rst_n | input | 1 | Active-low asynchronous reset of the write domain |
| wr_valid | input | 1 | Word present on the write side this cycle |
| wr_data | input | DATA_W | Data field of the incoming word |
| wr_stat | input | STAT_W | Status field of the incoming word |
| rd_clk | input | 1 | User logic clock (read domain) |
| rd_rst_n | input | 1 | Active-low asynchronous reset of the read domain |
| reg_mode | input | 1 | 1: single-register bypass; 0: phase compensation buffer |
| rd_valid | output | 1 | Output stream is live |
| rd_data | output | DATA_W | Data field of the outgoing word |
| rd_stat | output | STAT_W | Status field of the outgoing word |
| ovfl | output | 1 | Sticky overflow flag, write domain |
| unfl | output | 1 | Sticky underflow flag, read domain |

## Verification
In bypass mode, the result for a word is due exactly one `rd_clk` edge after it is driven. The bench drives each word on a falling edge and compares it on the next falling edge. In buffer mode, a word's exit time depends on the pointer crossing and the start threshold, so the bench does not predict a cycle. It instead checks every word leaving against the ordered list it wrote, and checks the counter increment when words are dropped. The flags are checked only after idle windows several times longer than the one-register pointer crossing, so each flag has settled before it is sampled.

// File: rtl/rx_phase_pkg.sv
`timescale 1ns/1ps
package rx_phase_pkg;
  localparam int RXPC_DEPTH  = 4;
  localparam int RXPC_AW     = $clog2(RXPC_DEPTH);
  localparam int RXPC_PW     = RXPC_AW + 1;
  localparam int RXPC_START  = 2;

  typedef logic [RXPC_PW-1:0] ptr_t;

  function automatic ptr_t to_gray(input ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t from_gray(input ptr_t g);
    ptr_t b;
    b[RXPC_PW-1] = g[RXPC_PW-1];
    for (int i = RXPC_PW - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction
endpackage

// File: rtl/rx_phase_sync.sv
`timescale 1ns/1ps
module rx_phase_sync #(
  parameter int W      = 3,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rx_phase_wr.sv
`timescale 1ns/1ps
module rx_phase_wr
  import rx_phase_pkg::*;
(
  input  logic               wr_clk,
  input  logic               wr_rst_n,
  input  logic               bypass,
  input  logic               wr_valid,
  input  ptr_t               rgray_seen,
  output logic               we,
  output logic [RXPC_AW-1:0] waddr,
  output ptr_t               wgray,
  output ptr_t               wfill,
  output logic               ovfl
);
  ptr_t wbin;
  ptr_t wbin_nxt;
  logic full;

  assign wfill    = wbin - from_gray(rgray_seen);
  assign full     = (wfill == ptr_t'(RXPC_DEPTH));
  assign we       = !bypass && wr_valid && !full;
  assign waddr    = wbin[RXPC_AW-1:0];
  assign wbin_nxt = wbin + ptr_t'(1);

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      ovfl  <= 1'b0;
    end else if (bypass) begin
      wbin  <= '0;
      wgray <= '0;
      ovfl  <= 1'b0;
    end else begin
      if (we) begin
        wbin  <= wbin_nxt;
        wgray <= to_gray(wbin_nxt);
      end
      if (wr_valid && full) ovfl <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_phase_rd.sv
`timescale 1ns/1ps
module rx_phase_rd
  import rx_phase_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic               rd_clk,
  input  logic               rd_rst_n,
  input  logic               bypass,
  input  ptr_t               wgray_seen,
  input  logic [WORD_W-1:0]  mem_word,
  input  logic [WORD_W-1:0]  byp_word,
  input  logic               byp_valid,
  output logic [RXPC_AW-1:0] raddr,
  output ptr_t               rgray,
  output ptr_t               rfill,
  output logic               started,
  output logic               empty,
  output logic [WORD_W-1:0]  out_word,
  output logic               out_valid,
  output logic               unfl
);
  ptr_t rbin;
  ptr_t rbin_nxt;
  logic go;

  assign rfill    = from_gray(wgray_seen) - rbin;
  assign empty    = (rfill == '0);
  assign go       = !bypass && (started || (rfill >= ptr_t'(RXPC_START)));
  assign raddr    = rbin[RXPC_AW-1:0];
  assign rbin_nxt = rbin + ptr_t'(1);

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rbin      <= '0;
      rgray     <= '0;
      started   <= 1'b0;
      unfl      <= 1'b0;
      out_word  <= '0;
      out_valid <= 1'b0;
    end else if (bypass) begin
      rbin      <= '0;
      rgray     <= '0;
      started   <= 1'b0;
      unfl      <= 1'b0;
      out_word  <= byp_word;
      out_valid <= byp_valid;
    end else begin
      started   <= go;
      out_valid <= go;
      if (go) begin
        if (!empty) begin
          out_word <= mem_word;
          rbin     <= rbin_nxt;
          rgray    <= to_gray(rbin_nxt);
        end else begin
          unfl <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rx_phase_fifo.sv
`timescale 1ns/1ps
module rx_phase_fifo
  import rx_phase_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int STAT_W      = 2,
  parameter int SYNC_STAGES = 1
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [STAT_W-1:0] wr_stat,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              reg_mode,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [STAT_W-1:0] rd_stat,
  output logic              ovfl,
  output logic              unfl
);
  localparam int WORD_W = DATA_W + STAT_W;

  logic               we;
  logic [RXPC_AW-1:0] waddr;
  logic [RXPC_AW-1:0] raddr;
  ptr_t               wgray, rgray, wgray_rd, rgray_wr;
  ptr_t               w_fill, r_fill;
  logic               r_started, r_empty;
  logic [WORD_W-1:0]  in_word, mem_word, out_word;
  logic [WORD_W-1:0]  store [RXPC_DEPTH];

  assign in_word = {wr_stat, wr_data};

  rx_phase_sync #(.W(RXPC_PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_wr)
  );

  rx_phase_sync #(.W(RXPC_PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_rd)
  );

  rx_phase_wr u_wr (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .bypass(reg_mode),
    .wr_valid(wr_valid), .rgray_seen(rgray_wr), .we(we),
    .waddr(waddr), .wgray(wgray), .wfill(w_fill), .ovfl(ovfl)
  );

  always_ff @(posedge wr_clk) begin
    if (we) store[waddr] <= in_word;
  end

  assign mem_word = store[raddr];

  rx_phase_rd #(.WORD_W(WORD_W)) u_rd (
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .bypass(reg_mode),
    .wgray_seen(wgray_rd), .mem_word(mem_word), .byp_word(in_word),
    .byp_valid(wr_valid), .raddr(raddr), .rgray(rgray), .rfill(r_fill),
    .started(r_started), .empty(r_empty), .out_word(out_word),
    .out_valid(rd_valid), .unfl(unfl)
  );

  assign {rd_stat, rd_data} = out_word;
endmodule

// File: rtl/rx_phase_fifo_chk.sv
`timescale 1ns/1ps
module rx_phase_fifo_chk
  import rx_phase_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STAT_W = 2
) (
  input logic              wr_clk,
  input logic              wr_rst_n,
  input logic              rd_clk,
  input logic              rd_rst_n,
  input logic              reg_mode,
  input logic              wr_valid,
  input logic [DATA_W-1:0] wr_data,
  input logic [STAT_W-1:0] wr_stat,
  input ptr_t              w_fill,
  input ptr_t              r_fill,
  input logic              r_started,
  input logic              r_empty,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [STAT_W-1:0] rd_stat,
  input logic              ovfl,
  input logic              unfl
);
  logic rd_live, wr_live;

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) rd_live <= 1'b0;
    else           rd_live <= 1'b1;
  end

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) wr_live <= 1'b0;
    else           wr_live <= 1'b1;
  end

  a_r5_depth_bound: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    w_fill <= ptr_t'(RXPC_DEPTH));

  a_r5_ovfl_sticky: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (ovfl && !reg_mode) |=> ovfl);

  a_r6_unfl_sticky: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (unfl && !reg_mode) |=> unfl);

  a_r6_hold_on_empty: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (!reg_mode && r_started && r_empty) |=> $stable({rd_stat, rd_data}));

  a_r4_keeps_valid: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (!reg_mode && rd_valid) |=> (rd_valid || reg_mode));

  a_r3_no_early_start: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (!reg_mode && !rd_valid && r_fill < ptr_t'(RXPC_START)) |=> !rd_valid);

  a_r7_one_cycle: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_live && reg_mode && $past(reg_mode)) |->
      ({rd_valid, rd_stat, rd_data} == $past({wr_valid, wr_stat, wr_data})));

  a_r8_quiet_unfl: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_live && reg_mode && $past(reg_mode)) |-> !unfl);

  a_r8_quiet_ovfl: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_live && reg_mode && $past(reg_mode)) |-> !ovfl);
endmodule

bind rx_phase_fifo rx_phase_fifo_chk #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
  .reg_mode(reg_mode), .wr_valid(wr_valid), .wr_data(wr_data), .wr_stat(wr_stat),
  .w_fill(w_fill), .r_fill(r_fill), .r_started(r_started), .r_empty(r_empty),
  .rd_valid(rd_valid), .rd_data(rd_data), .rd_stat(rd_stat),
  .ovfl(ovfl), .unfl(unfl)
);

// File: tb/rx_phase_fifo_bench.sv
`timescale 1ns/1ps
module rx_phase_fifo_bench;
  localparam int DW = 8;
  localparam int SW = 2;
  localparam int WW = DW + SW;

  logic          wr_clk = 1'b0, rd_clk = 1'b0;
  logic          wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic          wr_valid = 1'b0, reg_mode = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [SW-1:0] wr_stat = '0;
  logic          rd_valid, ovfl, unfl;
  logic [DW-1:0] rd_data;
  logic [SW-1:0] rd_stat;

  realtime wr_half = 2.0;
  int      n_chk = 0, n_fail = 0;

  logic [WW-1:0] exp_q [256];
  int            exp_n = 0, got_n = 0;
  int            sb_mode = 0;
  bit            seen_valid = 1'b0;
  logic [DW-1:0] last_d = '0;

  rx_phase_fifo #(.DATA_W(DW), .STAT_W(SW)) u_rx_phase_fifo (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_stat(wr_stat), .rd_clk(rd_clk),
    .rd_rst_n(rd_rst_n), .reg_mode(reg_mode), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_stat(rd_stat), .ovfl(ovfl), .unfl(unfl)
  );

  always #2 rd_clk = ~rd_clk;
  initial begin
    #1;
    forever #(wr_half) wr_clk = ~wr_clk;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Output scoreboard, sampled on the read clock falling edge.
  always @(negedge rd_clk) begin
    if (sb_mode == 1) begin
      if (rd_valid && got_n < exp_n) begin
        check({rd_stat, rd_data} == exp_q[got_n], "R2 word order", {rd_stat, rd_data}, exp_q[got_n]);
        got_n++;
        seen_valid = 1'b1;
      end else if (seen_valid && got_n < exp_n) begin
        check(rd_valid, "R4 valid held while streaming", rd_valid, 1);
      end
    end else if (sb_mode == 2) begin
      if (rd_valid && rd_data != last_d) begin
        check(rd_data > last_d, "R5 kept words in order", rd_data, last_d + 1);
        last_d = rd_data;
      end
    end
  end

  task automatic rd_cycles(input int n);
    repeat (n) @(negedge rd_clk);
  endtask

  task automatic full_reset(input logic mode);
    wr_valid = 1'b0;
    wr_rst_n = 1'b0;
    rd_rst_n = 1'b0;
    reg_mode = mode;
    sb_mode = 0;
    exp_n = 0;
    got_n = 0;
    seen_valid = 1'b0;
    last_d = '0;
    rd_cycles(3);
    wr_rst_n = 1'b1;
    rd_rst_n = 1'b1;
    rd_cycles(1);
  endtask

  task automatic push(input logic [WW-1:0] w);
    @(negedge wr_clk);
    wr_valid = 1'b1;
    {wr_stat, wr_data} = w;
    exp_q[exp_n] = w;
    exp_n++;
  endtask

  task automatic idle_wr(input int n);
    @(negedge wr_clk);
    wr_valid = 1'b0;
    repeat (n) @(negedge wr_clk);
  endtask

  function automatic logic [WW-1:0] pattern(input int p, input int i);
    logic [SW-1:0] s;
    logic [DW-1:0] d;
    case (p)
      0:       begin s = SW'(i);     d = DW'(i * 3 + 1); end
      1:       begin s = SW'(i + 1); d = i[0] ? 8'h55 : 8'hAA; end
      default: begin s = SW'(3 - i); d = DW'(1 << (i % DW)); end
    endcase
    return {s, d};
  endfunction

  initial begin
    // R1: reset state
    full_reset(1'b0);
    check(!rd_valid, "R1 rd_valid after reset", rd_valid, 0);
    check(!ovfl, "R1 ovfl after reset", ovfl, 0);
    check(!unfl, "R1 unfl after reset", unfl, 0);

    // R2/R3/R4/R6: streams in buffer mode, one per data pattern
    for (int p = 0; p < 3; p++) begin
      full_reset(1'b0);
      sb_mode = 1;
      push(pattern(p, 0));
      idle_wr(12);
      check(!rd_valid, "R3 no start on one word", rd_valid, 0);
      check(!unfl, "R3 no underflow before start", unfl, 0);
      for (int i = 1; i < 40; i++) push(pattern(p, i));
      idle_wr(2);
      rd_cycles(30);
      check(got_n == exp_n, "R2 all words delivered", got_n, exp_n);
      check(rd_valid, "R4 rd_valid stays high", rd_valid, 1);
      check(!ovfl, "R5 no overflow at equal rates", ovfl, 0);
      check(unfl, "R6 underflow after drain", unfl, 1);
      sb_mode = 0;
      for (int k = 0; k < 4; k++) begin
        rd_cycles(1);
        check({rd_stat, rd_data} == exp_q[exp_n-1], "R6 last word repeated",
              {rd_stat, rd_data}, exp_q[exp_n-1]);
      end
    end

    // R5: write clock twice as fast -> overflow, drop, sticky until wr reset
    full_reset(1'b0);
    sb_mode = 2;
    wr_half = 1.0;
    for (int i = 1; i <= 60; i++) push({SW'(i), DW'(i)});
    idle_wr(4);
    wr_half = 2.0;
    rd_cycles(20);
    check(ovfl, "R5 overflow flagged", ovfl, 1);
    rd_cycles(10);
    check(ovfl, "R5 overflow sticky", ovfl, 1);
    sb_mode = 0;
    wr_rst_n = 1'b0;
    rd_cycles(2);
    check(!ovfl, "R5 overflow cleared by wr reset", ovfl, 0);
    check(unfl, "R6 underflow unaffected by wr reset", unfl, 1);
    rd_rst_n = 1'b0;
    rd_cycles(2);
    check(!unfl, "R6 underflow cleared by rd reset", unfl, 0);
    wr_rst_n = 1'b1;
    rd_rst_n = 1'b1;

    // R7/R8: bypass register, fast write clock, shared read clock timing
    full_reset(1'b1);
    wr_half = 1.0;
    begin
      logic [WW:0] prev;
      prev = '0;
      for (int i = 0; i < 32; i++) begin
        @(negedge rd_clk);
        if (i > 0)
          check({rd_valid, rd_stat, rd_data} == prev, "R7 one-cycle bypass",
                {rd_valid, rd_stat, rd_data}, prev);
        wr_valid = (i % 3) != 0;
        wr_data  = DW'(i * 7 + 3);
        wr_stat  = SW'(i);
        prev     = {wr_valid, wr_stat, wr_data};
      end
    end
    wr_valid = 1'b0;
    rd_cycles(4);
    check(!ovfl, "R8 no overflow in bypass", ovfl, 0);
    check(!unfl, "R8 no underflow in bypass", unfl, 0);
    wr_half = 2.0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule